// File: doc/BRIEF.md
# Deferred-Readback Memory Sweep Tester

This block is a hardware test engine that finds memory devices that are missing, dead or wired wrongly. It drives a simple synchronous memory port. One start pulse runs a test over a region set by a base address and a word count. Each word in the region gets a value of its own. All words are written first. Only after the last write does the engine read the region back and compare each word. A missing device can leave the last written value floating on the data lines. Because no word is read back until every word has been written, that leftover charge returns the final value instead of the first one, and the test fails.

The engine runs only while a qualifier input reports that the data bus and address bus checks have already passed. The test stops at the first mismatch. It then holds the failing address, the expected value and the observed value until the next run. A fault on a control line shows up here too, but only as a plain device failure. The value for word `i` is `i + 1` truncated to the data width. In a region longer than `2^DATA_W` words the values therefore repeat, and an absent device can escape detection when the first and last values happen to coincide.

Top module: `mem_sweep_tester`

## Requirements
- R1: A start pulse is taken only while `busy` is low and `bus_ok` is high. A start seen with `bus_ok` low causes no memory access and leaves `done`, `fail` and `busy` unchanged.
- R2: In the write phase, word `i` of `N` is written to `base_addr + i` with data `(i + 1) mod 2^DATA_W`. Writes go one per cycle in ascending order of `i`, on `mem_we`.
- R3: No read (`mem_re` high) is issued until all `N` writes of the current run have been issued.
- R4: In the read phase, reads go in ascending order of address starting at `base_addr`. The data for a read is taken from `mem_rdata` in the cycle that lies `RD_LAT` cycles after the cycle in which `mem_re` is high.
- R5: When every word reads back its own value, the run ends with `done` high and `fail` low.
- R6: At the first mismatch, read issue stops and the run ends with `done` and `fail` high. `fail_addr`, `exp_data` and `obs_data` hold the address, the expected value and the read value of that first failing word. Reads still in flight do not overwrite them.
- R7: When the memory returns the last written value for every read, as an absent device does, the run fails at `base_addr` with expected data 1 and observed data `N mod 2^DATA_W` (for N > 1).
- R8: A start pulse that arrives while `busy` is high has no effect on the running test, its addresses or its result.
- R9: `done` and `fail` hold their values after a run until the next accepted start, which clears `done` on the following edge. A synchronous reset clears `done`, `fail`, `busy`, `mem_we` and `mem_re`.
- R10: A run with `word_count` of 0 makes no memory access. It ends with `done` high and `fail` low.
- R11: `busy` is high from the cycle after an accepted start until `done` rises, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse |
| bus_ok | input | 1 | Qualifier: bus wiring checks have passed |
| base_addr | input | ADDR_W | First word of the region |
| word_count | input | ADDR_W+1 | Number of words in the region |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | DATA_W | Memory read data, RD_LAT cycles after the read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished; held until the next launch |
| fail | output | 1 | A mismatch was found |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| exp_data | output | DATA_W | Expected value at the first mismatch |
| obs_data | output | DATA_W | Value read at the first mismatch |

## Verification
The bench uses a memory model that can act as an absent device (every read returns the last value on the bus), alias one address bit, or corrupt a single stored word. An engine that read each word right after writing it would pass the absent case, and this shows as a missing failure. An engine that sampled read data in the wrong cycle would flag a good memory or report the wrong observed value. If the first-mismatch record were overwritten by reads still in flight, the alias and absent cases would report a later address. The bench also covers a region longer than the value range, a zero-length region, start pulses that come while busy or while the qualifier is low, and a reset in the middle of a run. A wrong guard on any of these shows up as stray memory traffic or a changed result.

// File: rtl/mst_pkg.sv
package mst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_READ,
    ST_DRAIN,
    ST_DONE
  } mst_state_e;
endpackage

// File: rtl/mst_seq.sv
module mst_seq
  import mst_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bus_ok,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              fail_seen,
  input  logic              pipe_busy,
  output logic              launch,
  output logic              wr_go,
  output logic              rd_go,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  cur_idx,
  output logic              busy,
  output logic              done
);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  mst_state_e        state;
  logic [CNT_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;
  logic              last;

  assign last     = (idx == cnt_q - ONE_C);
  assign launch   = start && bus_ok && (state == ST_IDLE || state == ST_DONE);
  assign wr_go    = (state == ST_WRITE);
  assign rd_go    = (state == ST_READ) && !fail_seen;
  assign cur_addr = base_q + idx[ADDR_W-1:0];
  assign cur_idx  = idx;
  assign busy     = (state == ST_WRITE) || (state == ST_READ) || (state == ST_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      idx    <= '0;
      cnt_q  <= '0;
      base_q <= '0;
      done   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE, ST_DONE: begin
          if (launch) begin
            base_q <= base_addr;
            cnt_q  <= word_count;
            idx    <= '0;
            done   <= 1'b0;
            state  <= (word_count == '0) ? ST_DRAIN : ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (last) begin
            idx   <= '0;
            state <= ST_READ;
          end else begin
            idx <= idx + ONE_C;
          end
        end
        ST_READ: begin
          if (fail_seen || last) state <= ST_DRAIN;
          else                   idx   <= idx + ONE_C;
        end
        ST_DRAIN: begin
          if (!pipe_busy) begin
            state <= ST_DONE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mst_rd_pipe.sv
module mst_rd_pipe #(
  parameter int LAT    = 1,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_exp,
  output logic              out_vld,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_exp,
  output logic              any_vld
);
  localparam int STAGES = LAT + 1;

  logic [STAGES-1:0] vld;
  logic [ADDR_W-1:0] addr_s [STAGES];
  logic [DATA_W-1:0] exp_s  [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) vld[0] <= 1'b0;
        else     vld[0] <= in_vld;
        addr_s[0] <= in_addr;
        exp_s[0]  <= in_exp;
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (rst) vld[g] <= 1'b0;
        else     vld[g] <= vld[g-1];
        addr_s[g] <= addr_s[g-1];
        exp_s[g]  <= exp_s[g-1];
      end
    end
  end

  assign out_vld  = vld[STAGES-1];
  assign out_addr = addr_s[STAGES-1];
  assign out_exp  = exp_s[STAGES-1];
  assign any_vld  = |vld;
endmodule

// File: rtl/mst_cmp.sv
module mst_cmp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              chk_vld,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [DATA_W-1:0] chk_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] exp_data,
  output logic [DATA_W-1:0] obs_data
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      exp_data  <= '0;
      obs_data  <= '0;
    end else if (chk_vld && !fail && (rdata != chk_exp)) begin
      fail      <= 1'b1;
      fail_addr <= chk_addr;
      exp_data  <= chk_exp;
      obs_data  <= rdata;
    end
  end
endmodule

// File: rtl/mem_sweep_tester.sv
module mem_sweep_tester #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              bus_ok,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W:0]   word_count,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] exp_data,
  output logic [DATA_W-1:0] obs_data
);
  localparam int CNT_W = ADDR_W + 1;

  logic              launch, wr_go, rd_go, pipe_busy;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_idx;
  logic [DATA_W-1:0] pat;
  logic              chk_vld;
  logic [ADDR_W-1:0] chk_addr;
  logic [DATA_W-1:0] chk_exp;

  assign pat = DATA_W'(cur_idx + CNT_W'(1));

  mst_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .bus_ok(bus_ok),
    .base_addr(base_addr), .word_count(word_count),
    .fail_seen(fail), .pipe_busy(pipe_busy),
    .launch(launch), .wr_go(wr_go), .rd_go(rd_go),
    .cur_addr(cur_addr), .cur_idx(cur_idx), .busy(busy), .done(done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= wr_go;
      mem_re <= rd_go;
      if (wr_go || rd_go) mem_addr  <= cur_addr;
      if (wr_go)          mem_wdata <= pat;
    end
  end

  mst_rd_pipe #(.LAT(RD_LAT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst(rst), .in_vld(rd_go), .in_addr(cur_addr), .in_exp(pat),
    .out_vld(chk_vld), .out_addr(chk_addr), .out_exp(chk_exp), .any_vld(pipe_busy)
  );

  mst_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .clear(launch),
    .chk_vld(chk_vld), .chk_addr(chk_addr), .chk_exp(chk_exp), .rdata(mem_rdata),
    .fail(fail), .fail_addr(fail_addr), .exp_data(exp_data), .obs_data(obs_data)
  );
endmodule

// File: rtl/mst_chk.sv
module mst_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              bus_ok,
  input logic [ADDR_W:0]   word_count,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_we,
  input logic              mem_re,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr
);
  localparam logic [ADDR_W:0]   ONE_C = 1;
  localparam logic [ADDR_W-1:0] ONE_A = 1;
  localparam logic [DATA_W-1:0] ONE_D = 1;

  logic [ADDR_W:0] wr_seen, cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_seen <= '0;
      cnt_q   <= '0;
    end else if (start && bus_ok && !busy) begin
      wr_seen <= '0;
      cnt_q   <= word_count;
    end else if (mem_we) begin
      wr_seen <= wr_seen + ONE_C;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(start && bus_ok)) |=> (!mem_we && !mem_re));

  // R2
  write_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |->
      (mem_addr == $past(mem_addr) + ONE_A) && (mem_wdata == $past(mem_wdata) + ONE_D));

  // R3
  read_after_writes_chk: assert property (@(posedge clk) disable iff (rst)
    mem_re |-> (wr_seen == cnt_q));

  // R6
  first_fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fail && $past(fail)) |-> $stable(fail_addr));

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !(start && bus_ok)) |=> (done && $stable(fail)));

  // R11
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
endmodule

bind mem_sweep_tester mst_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mst_chk (
  .clk(clk), .rst(rst), .start(start), .bus_ok(bus_ok), .word_count(word_count),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
  .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
);

// File: tb/test_mem_sweep_tester.sv
module test_mem_sweep_tester;
  localparam int AW = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic bus_ok = 1'b1;
  logic [AW-1:0] base_addr = '0;
  logic [AW:0]   word_count = '0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic [DW-1:0] mem_wdata, exp_data, obs_data;
  logic [DW-1:0] mem_rdata = '0;
  logic mem_we, mem_re, busy, done, fail;

  always #2 clk = ~clk;

  mem_sweep_tester #(.ADDR_W(AW), .DATA_W(DW), .RD_LAT(1)) i_mem_sweep_tester (
    .clk(clk), .rst(rst), .start(start), .bus_ok(bus_ok),
    .base_addr(base_addr), .word_count(word_count),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .exp_data(exp_data), .obs_data(obs_data)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] patf(input int i);
    return DW'(i + 1);
  endfunction

  // Memory model with fault injection
  logic [DW-1:0] mem [0:(1<<AW)-1];
  logic [DW-1:0] bus_last = '0;
  bit            m_absent = 0;
  logic [AW-1:0] m_stk_a = '0;
  logic [DW-1:0] m_stk_m = '0;
  logic [AW-1:0] m_alias = '0;

  function automatic logic [AW-1:0] phys(input logic [AW-1:0] a);
    return a & ~m_alias;
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      mem[phys(mem_addr)] <= mem_wdata;
      bus_last <= mem_wdata;
    end
    if (mem_re)
      mem_rdata <= m_absent ? bus_last
                 : (mem[phys(mem_addr)] | ((mem_addr == m_stk_a) ? m_stk_m : '0));
  end

  // Scoreboard
  typedef struct {
    bit            f;
    logic [AW-1:0] a;
    logic [DW-1:0] e;
    logic [DW-1:0] o;
    string         tag;
  } exp_t;
  exp_t sb[$];

  logic [AW-1:0] cur_base = '0;
  int cur_n = 0;
  int wr_i = 0;
  int rd_i = 0;
  int acc = 0;
  bit prev_done = 0;

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (start && bus_ok && !busy) begin
        wr_i = 0;
        rd_i = 0;
      end
      if (mem_we || mem_re) acc++;
      if (mem_we) begin
        chk(mem_addr == AW'(cur_base + wr_i), "R2", "write addr", mem_addr, AW'(cur_base + wr_i));
        chk(mem_wdata == patf(wr_i), "R2", "write data", mem_wdata, patf(wr_i));
        wr_i++;
      end
      if (mem_re) begin
        chk(wr_i == cur_n, "R3", "writes before read", wr_i, cur_n);
        chk(mem_addr == AW'(cur_base + rd_i), "R4", "read addr", mem_addr, AW'(cur_base + rd_i));
        rd_i++;
      end
      if (done && !prev_done) begin
        if (sb.size() == 0) begin
          chk(0, "R5", "unexpected done", 1, 0);
        end else begin
          exp_t x;
          x = sb.pop_front();
          chk(fail == x.f, x.tag, "fail flag", fail, x.f);
          if (x.f) begin
            chk(fail_addr == x.a, x.tag, "fail addr", fail_addr, x.a);
            chk(exp_data == x.e, x.tag, "expected data", exp_data, x.e);
            chk(obs_data == x.o, x.tag, "observed data", obs_data, x.o);
          end
        end
      end
    end
    prev_done = done;
  end

  task automatic pulse_start(input logic [AW-1:0] b, input int n);
    @(posedge clk); #1;
    base_addr = b; word_count = (AW+1)'(n); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_case(input logic [AW-1:0] b, input int n, input bit ab,
                          input logic [AW-1:0] sa, input logic [DW-1:0] sm,
                          input logic [AW-1:0] am, input bit poke, input string tag);
    logic [DW-1:0] sh [0:(1<<AW)-1];
    exp_t x;
    m_absent = ab; m_stk_a = sa; m_stk_m = sm; m_alias = am;
    cur_base = b; cur_n = n;
    for (int i = 0; i < (1<<AW); i++) sh[i] = '0;
    for (int i = 0; i < n; i++) sh[phys(AW'(b + i))] = patf(i);
    x.f = 0; x.a = '0; x.e = '0; x.o = '0; x.tag = tag;
    for (int i = 0; i < n; i++) begin
      logic [AW-1:0] ad;
      logic [DW-1:0] ob;
      ad = AW'(b + i);
      ob = ab ? patf(n - 1) : (sh[phys(ad)] | ((ad == sa) ? sm : '0));
      if (!x.f && ob != patf(i)) begin
        x.f = 1; x.a = ad; x.e = patf(i); x.o = ob;
      end
    end
    sb.push_back(x);
    pulse_start(b, n);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done cleared by launch", done, 0);
    chk(busy == 1'b1, "R11", "busy after launch", busy, 1);
    if (poke) begin
      repeat (4) @(posedge clk);
      #1; base_addr = AW'(10'h300); word_count = 11'd5; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int snap;
    bit fsnap;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!done && !fail && !busy && !mem_we && !mem_re, "R9", "reset state",
        {done, fail, busy, mem_we, mem_re}, 0);

    // R1: start with qualifier low
    snap = acc;
    bus_ok = 1'b0;
    pulse_start(10'h040, 8);
    repeat (6) @(negedge clk);
    chk(acc == snap, "R1", "no access without qualifier", acc, snap);
    chk(!busy && !done, "R1", "state unchanged", {busy, done}, 0);
    bus_ok = 1'b1;

    // R5 good memory
    run_case(10'h040, 20, 0, '0, '0, '0, 0, "R5");

    // R9 hold
    fsnap = fail;
    repeat (4) @(negedge clk);
    chk(done == 1'b1, "R9", "done held", done, 1);
    chk(fail == fsnap, "R9", "fail held", fail, fsnap);

    // R8 start while busy
    run_case(10'h100, 12, 0, '0, '0, '0, 1, "R8");
    chk(wr_i == 12 && rd_i == 12, "R8", "access count after poke", wr_i * 100 + rd_i, 1212);

    // R7 absent device
    run_case(10'h200, 10, 1, '0, '0, '0, 0, "R7");

    // R6 stuck bit at one word, read issue stops early
    run_case(10'h010, 16, 0, 10'h013, 8'h80, '0, 0, "R6");
    chk(rd_i <= 7, "R6", "reads after mismatch bounded", rd_i, 7);

    // R6 aliased address bit
    run_case(10'h000, 16, 0, '0, '0, 10'h008, 0, "R6");

    // R2 value wrap over long region
    run_case(10'h080, 300, 0, '0, '0, '0, 0, "R2");

    // R10 empty region
    snap = acc;
    run_case(10'h050, 0, 0, '0, '0, '0, 0, "R10");
    chk(acc == snap, "R10", "no access for zero count", acc, snap);

    // R9 reset mid-run
    cur_base = 10'h060; cur_n = 50; m_absent = 0; m_stk_m = '0; m_alias = '0;
    pulse_start(10'h060, 50);
    repeat (10) @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    @(negedge clk);
    chk(!done && !fail && !busy && !mem_we && !mem_re, "R9", "mid-run reset",
        {done, fail, busy, mem_we, mem_re}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    chk(sb.size() == 0, "R5", "scoreboard drained", sb.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule